// File: doc/BRIEF.md
# Optical Black Clamp Loop

This block keeps the black level of one image-sensor channel at a programmed target. Each line of the sensor starts with a short run of shielded pixels, and a clamp pulse marks that run. While the pulse is high, every valid 12-bit converter sample is compared against an 8-bit target level and the differences are summed. When the pulse falls, the block averages the summed error and scales it down by a factor of eight. It then adds the result to a signed 10-bit correction code. That code drives the offset DAC in front of the converter, which closes the feedback loop.

The loop normally closes once per line. It also behaves correctly when clamp pulses come less often or at uneven spacing, because each window starts from cleared sums. A window of twenty or more samples gives a quiet correction. Shorter windows are accepted, at the cost of a noisier step. When the loop enable is low, the correction code simply follows the target level as a fixed offset. This suits systems that clamp digitally further down the pipeline. When the loop is enabled again, the integrator starts from that offset.

Top module: `bo_clamp_loop`

## Requirements
- R1: While reset is asserted and on its release, `dac_code` is 0 and `dac_upd` is 0.
- R2: While `loop_en` is 0, `dac_code` takes the zero-extended `clamp_lvl` one clock after it is presented, and `dac_upd` stays 0, whatever the clamp pulse and samples do.
- R3: A sample enters the window sum only in a cycle where both `clamp_pulse` and `smp_valid` are 1. Data in other cycles has no effect on the code.
- R4: A window ends in the first cycle `clamp_pulse` is low after being high. With the loop enabled, the code is registered at that cycle's clock edge and `dac_upd` is 1 for exactly that one following cycle.
- R5: For a window with m counted samples, let 2^k be the largest power of two not above m. The error is the sum of (`clamp_lvl` − sample) over the first 2^k samples, arithmetically shifted right by k. The new code is the old code plus (error arithmetically shifted right by 3).
- R6: At most 64 samples per window are counted. Later samples in the same window are ignored.
- R7: The new code saturates to the range −512..511.
- R8: A window with no counted samples leaves the code unchanged and raises no `dac_upd`.
- R9: While the loop is enabled, `dac_code` changes only in cycles where `dac_upd` is 1.
- R10: If `loop_en` goes low in the same cycle a window ends, the static offset load wins and no update pulse occurs.
- R11: Windows are independent. A window separated from the previous one by a single low cycle uses only its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned converter sample |
| clamp_pulse | input | 1 | High during the shielded-pixel window |
| loop_en | input | 1 | 1 closes the loop, 0 applies the static offset |
| clamp_lvl | input | 8 | Black target level in LSB |
| dac_code | output | 10 | Signed correction code to the offset DAC |
| dac_upd | output | 1 | One-cycle pulse when a loop update lands |

## Verification
Two events can land on the same clock edge: the end-of-window update and a switch of the loop into its static mode. The bench provokes this by lowering the clamp pulse and the loop enable on the same cycle, with a new target level. It judges the result by the code holding exactly the new level, with no update pulse appearing at the scoreboard. A second coincidence is tested with back-to-back windows. Here one window's closing edge is also the edge right before the next window's first sample, and the bench expects the second result to reflect only the second window's data.

// File: rtl/bo_pkg.sv
package bo_pkg;
  // source selected for the next correction code
  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_STATIC = 2'd1,
    UPD_LOOP   = 2'd2
  } upd_sel_e;
endpackage

// File: rtl/bo_err_accum.sv
module bo_err_accum #(
  parameter int SMP_W   = 12,
  parameter int LVL_W   = 8,
  parameter int MAX_LOG = 6,
  localparam int ERR_W  = SMP_W + 2,
  localparam int ACC_W  = ERR_W + MAX_LOG,
  localparam int CNT_W  = MAX_LOG + 1,
  localparam int KW     = $clog2(MAX_LOG + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [SMP_W-1:0]        smp_data,
  input  logic                    clamp_pulse,
  input  logic [LVL_W-1:0]        clamp_lvl,
  input  logic                    win_end,
  output logic signed [ERR_W-1:0] avg_err,
  output logic                    has_smp
);
  localparam int MAX_N = 1 << MAX_LOG;

  logic signed [ACC_W-1:0] sum_q, sum_n, psum_q, psum_n, shr;
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [KW-1:0]           k_q, k_n;
  logic signed [ERR_W-1:0] err;
  logic                    take;

  // per-sample error: target minus sample
  assign err  = $signed({{(ERR_W-LVL_W){1'b0}}, clamp_lvl})
              - $signed({{(ERR_W-SMP_W){1'b0}}, smp_data});
  assign take = clamp_pulse && smp_valid && (cnt_q < CNT_W'(MAX_N));

  always_comb begin
    sum_n  = sum_q;
    cnt_n  = cnt_q;
    psum_n = psum_q;
    k_n    = k_q;
    if (win_end) begin
      sum_n  = '0;
      cnt_n  = '0;
      psum_n = '0;
      k_n    = '0;
    end else if (take) begin
      sum_n = sum_q + ACC_W'(err);
      cnt_n = cnt_q + CNT_W'(1);
      // snapshot the sum each time the count hits a power of two
      for (int i = 0; i <= MAX_LOG; i++) begin
        if (cnt_n == (CNT_W'(1) << i)) begin
          psum_n = sum_n;
          k_n    = KW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      psum_q <= '0;
      k_q    <= '0;
    end else begin
      sum_q  <= sum_n;
      cnt_q  <= cnt_n;
      psum_q <= psum_n;
      k_q    <= k_n;
    end
  end

  assign shr     = psum_q >>> k_q;
  assign avg_err = shr[ERR_W-1:0];
  assign has_smp = (cnt_q != '0);
endmodule

// File: rtl/bo_filter.sv
module bo_filter
  import bo_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int ERR_W   = 14,
  parameter int DAC_W   = 10,
  parameter int GAIN_SH = 3,
  localparam int SUM_W  = ((ERR_W > DAC_W) ? ERR_W : DAC_W) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loop_en,
  input  logic [LVL_W-1:0]        clamp_lvl,
  input  logic                    win_end,
  input  logic                    has_smp,
  input  logic signed [ERR_W-1:0] avg_err,
  output logic signed [DAC_W-1:0] code,
  output logic                    upd
);
  localparam int CODE_MAX = (1 << (DAC_W - 1)) - 1;
  localparam int CODE_MIN = -(1 << (DAC_W - 1));

  logic signed [DAC_W-1:0] code_q, code_n;
  logic                    upd_q, upd_n;
  logic signed [ERR_W-1:0] step;
  logic signed [SUM_W-1:0] wide;
  upd_sel_e                sel;

  assign step = avg_err >>> GAIN_SH;
  assign wide = SUM_W'(code_q) + SUM_W'(step);

  always_comb begin
    if (!loop_en)                sel = UPD_STATIC;
    else if (win_end && has_smp) sel = UPD_LOOP;
    else                         sel = UPD_HOLD;
  end

  always_comb begin
    code_n = code_q;
    upd_n  = 1'b0;
    unique case (sel)
      UPD_STATIC: code_n = $signed({{(DAC_W-LVL_W){1'b0}}, clamp_lvl});
      UPD_LOOP: begin
        upd_n = 1'b1;
        if (wide > SUM_W'(CODE_MAX))      code_n = DAC_W'(CODE_MAX);
        else if (wide < SUM_W'(CODE_MIN)) code_n = DAC_W'(CODE_MIN);
        else                              code_n = wide[DAC_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      upd_q  <= upd_n;
    end
  end

  assign code = code_q;
  assign upd  = upd_q;
endmodule

// File: rtl/bo_clamp_loop.sv
module bo_clamp_loop #(
  parameter int SMP_W   = 12,
  parameter int LVL_W   = 8,
  parameter int DAC_W   = 10,
  parameter int MAX_LOG = 6,
  parameter int GAIN_SH = 3,
  localparam int ERR_W  = SMP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             clamp_pulse,
  input  logic             loop_en,
  input  logic [LVL_W-1:0] clamp_lvl,
  output logic [DAC_W-1:0] dac_code,
  output logic             dac_upd
);
  logic                    pulse_d;
  logic                    win_end;
  logic                    has_smp;
  logic signed [ERR_W-1:0] avg_err;
  logic signed [DAC_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_d <= 1'b0;
    else        pulse_d <= clamp_pulse;
  end

  assign win_end = pulse_d && !clamp_pulse;

  bo_err_accum #(
    .SMP_W(SMP_W), .LVL_W(LVL_W), .MAX_LOG(MAX_LOG)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .clamp_pulse(clamp_pulse), .clamp_lvl(clamp_lvl), .win_end(win_end),
    .avg_err(avg_err), .has_smp(has_smp)
  );

  bo_filter #(
    .LVL_W(LVL_W), .ERR_W(ERR_W), .DAC_W(DAC_W), .GAIN_SH(GAIN_SH)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clamp_lvl(clamp_lvl),
    .win_end(win_end), .has_smp(has_smp), .avg_err(avg_err),
    .code(code), .upd(dac_upd)
  );

  assign dac_code = code;
endmodule

// File: rtl/bo_clamp_loop_chk.sv
module bo_clamp_loop_chk #(
  parameter int LVL_W = 8,
  parameter int DAC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clamp_pulse,
  input logic             loop_en,
  input logic [LVL_W-1:0] clamp_lvl,
  input logic [DAC_W-1:0] dac_code,
  input logic             dac_upd
);
  // R2 and R10: disabled loop loads the static level, never pulses
  a_r2_static_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(loop_en)) |->
      (dac_code == {{(DAC_W-LVL_W){1'b0}}, $past(clamp_lvl)}) && !dac_upd);

  // R4: an update follows a low clamp pulse with the loop enabled
  a_r4_upd_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |-> (!$past(clamp_pulse) && $past(loop_en)));

  // R4: update strobe is a single cycle
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |=> !dac_upd);

  // R9: enabled loop holds the code between updates
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_en) && !dac_upd) |-> $stable(dac_code));
endmodule

bind bo_clamp_loop bo_clamp_loop_chk #(.LVL_W(LVL_W), .DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clamp_pulse(clamp_pulse), .loop_en(loop_en),
  .clamp_lvl(clamp_lvl), .dac_code(dac_code), .dac_upd(dac_upd)
);

// File: tb/bo_clamp_loop_test.sv
module bo_clamp_loop_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic [11:0] smp_data;
  logic       clamp_pulse;
  logic       loop_en;
  logic [7:0] clamp_lvl;
  logic [9:0] dac_code;
  logic       dac_upd;

  int total = 0;
  int bad   = 0;
  int model = 0;
  int expq[$];

  always #10 clk = ~clk;

  bo_clamp_loop uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .clamp_pulse(clamp_pulse), .loop_en(loop_en), .clamp_lvl(clamp_lvl),
    .dac_code(dac_code), .dac_upd(dac_upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each update pulse pops one expected code (R4, R5)
  always @(negedge clk) begin
    if (rst_n && dac_upd) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected update", $signed(dac_code), 0);
      end else begin
        int e;
        e = expq.pop_front();
        chk($signed(dac_code) == e, "R5 update value", $signed(dac_code), e);
      end
    end
  end

  // driver: one clamp window; samples at index >= cut take value tail
  task automatic run_win(input int n, input int base, input int stp,
                         input int cut, input int tail, input bit gaps,
                         input bit drop_en, input int new_lvl, input int post);
    int smp[$];
    clamp_pulse = 1'b1;
    if (n == 0) repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int v;
      v = (i >= cut) ? tail : base + i * stp;
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      if (gaps && (i % 3 == 1)) begin
        smp_valid = 1'b0;
        smp_data  = 12'hfff;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data  = 12'(v);
      smp.push_back(v);
      @(negedge clk);
    end
    clamp_pulse = 1'b0;
    smp_valid   = 1'b0;
    smp_data    = 12'hfff;
    if (drop_en) begin
      loop_en   = 1'b0;
      clamp_lvl = 8'(new_lvl);
      model     = new_lvl;
    end else if (loop_en && smp.size() > 0) begin
      int m, p, k, s, avg;
      m = (smp.size() > 64) ? 64 : smp.size();
      p = 1; k = 0;
      while (p * 2 <= m) begin p = p * 2; k++; end
      s = 0;
      for (int i = 0; i < p; i++) s += int'(clamp_lvl) - smp[i];
      avg   = s >>> k;
      model = model + (avg >>> 3);
      if (model > 511)  model = 511;
      if (model < -512) model = -512;
      expq.push_back(model);
    end
    repeat (post) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    clamp_pulse = 1'b0; loop_en = 1'b0; clamp_lvl = '0;
    repeat (3) @(negedge clk);
    chk(dac_code == 0, "R1 reset code", dac_code, 0);
    chk(dac_upd == 0, "R1 reset strobe", dac_upd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_code == 0, "R1 code after release", dac_code, 0);

    // R2: static offset follows the level
    clamp_lvl = 8'd77;
    @(negedge clk);
    chk(dac_code == 77, "R2 static load", dac_code, 77);
    run_win(10, 0, 0, 99, 0, 1'b0, 1'b0, 0, 3);
    chk(dac_code == 77, "R2 window ignored while disabled", dac_code, 77);

    // enable the loop from a static offset of 100
    clamp_lvl = 8'd100;
    @(negedge clk);
    model = 100;
    loop_en = 1'b1;
    @(negedge clk);
    chk($signed(dac_code) == 100, "R9 code held after enable", $signed(dac_code), 100);

    // R3: gaps carry garbage data that must not count
    run_win(32, 300, 0, 99, 0, 1'b1, 1'b0, 0, 3);
    // R5: five samples, only the first four count
    clamp_lvl = 8'd100;
    run_win(5, 40, 0, 4, 4095, 1'b0, 1'b0, 0, 3);
    // R6: samples past 64 are ignored
    run_win(80, 200, 0, 64, 4095, 1'b0, 1'b0, 0, 3);
    // R5: ramp, short window of 20
    run_win(20, 0, 60, 99, 0, 1'b1, 1'b0, 0, 3);
    // R8: window without samples
    run_win(0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 3);
    chk($signed(dac_code) == model, "R8 empty window keeps code", $signed(dac_code), model);
    // R11: back-to-back windows one low cycle apart
    run_win(8, 90, 0, 99, 0, 1'b0, 1'b0, 0, 1);
    run_win(8, 130, 0, 99, 0, 1'b0, 1'b0, 0, 3);
    chk($signed(dac_code) == model, "R11 independent windows", $signed(dac_code), model);

    // R7: positive saturation
    clamp_lvl = 8'd255;
    for (int w = 0; w < 24; w++) run_win(64, 0, 0, 99, 0, 1'b0, 1'b0, 0, 2);
    chk($signed(dac_code) == 511, "R7 upper limit", $signed(dac_code), 511);
    // R7: negative saturation
    clamp_lvl = 8'd0;
    for (int w = 0; w < 4; w++) run_win(16, 4095, 0, 99, 0, 1'b0, 1'b0, 0, 2);
    chk($signed(dac_code) == -512, "R7 lower limit", $signed(dac_code), -512);

    // R10: disable lands on the window's closing edge
    clamp_lvl = 8'd0;
    run_win(16, 3000, 0, 99, 0, 1'b0, 1'b1, 50, 3);
    chk(dac_code == 50, "R10 static wins over update", dac_code, 50);

    chk(expq.size() == 0, "R4 all updates seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule